// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Unit

This unit freezes a logic region while a power-down request is present on either of two request pins. It sits on both sides of the core. On the input side it stands between the pad inputs and the core logic. On the output side it stands between the core's data and enable outputs and the pad drivers. On the clock edge where a request is first seen, it captures the pad input values, the core output data and the core output enables. It then presents those captured values for as long as the request lasts. Any pad input change during that time does not reach the core. Any core output change does not reach the pads. A driver that was in high impedance at entry stays in high impedance.

A static configuration bit turns the feature on. While the feature is on, the two request pins serve only as power-down controls, and the logic view of them given to the core is forced low. While the feature is off, the request pins are ordinary inputs: the core sees them unchanged, and no hold ever takes place. The request pins themselves are never frozen. They are observed every cycle, so the unit is released in the first cycle after both pins are seen low at a clock edge. A status output is high while the hold is in effect.

Top module: `pdh_unit`

## Requirements
- R1: After reset is released and before any request is seen, holdActive is 0, coreIn equals padIn, padOut equals coreOut, and padOe equals coreOe, all in the same cycle.
- R2: A request is present when cfgPdEnable is 1 and at least one of pdReq[0] or pdReq[1] is 1. holdActive rises at the first rising clock edge where a request is present. It stays 1 at every following edge where a request is present.
- R3: While holdActive is 1, coreIn equals the padIn value sampled at the entry edge, and changes on padIn have no effect on coreIn.
- R4: While holdActive is 1, padOut equals the coreOut value sampled at the entry edge, and changes on coreOut have no effect on padOut.
- R5: While holdActive is 1, padOe equals the coreOe value sampled at the entry edge. A bit that was 0 (high impedance) at entry stays 0 even if coreOe later sets it to 1.
- R6: At the first rising edge where no request is present, holdActive falls. From that cycle on, coreIn, padOut and padOe again follow padIn, coreOut and coreOe.
- R7: With cfgPdEnable 1, pdPinLogic is 00 whatever pdReq is. With cfgPdEnable 0, pdPinLogic equals pdReq, and holdActive stays 0 whatever pdReq is.
- R8: Either request pin alone starts a hold. Handing the request from one pin to the other without a gap keeps the hold, and the held values are not captured again.
- R9: While holdActive is 0, all three paths pass their live inputs through in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgPdEnable | input | 1 | Static enable of the power-down feature |
| pdReq | input | 2 | The two power-down request pins |
| padIn | input | NUM_IN | Live pad input values |
| coreIn | output | NUM_IN | Input values presented to the core |
| pdPinLogic | output | 2 | Logic view of the request pins given to the core |
| coreOut | input | NUM_OUT | Output data from the core |
| coreOe | input | NUM_OUT | Output enables from the core, 1 drives the pad |
| padOut | output | NUM_OUT | Data to the pad drivers |
| padOe | output | NUM_OUT | Enables to the pad drivers |
| holdActive | output | 1 | High while the hold is in effect |

## Verification
The pass-through path is tried with several different values on padIn, coreOut and coreOe, both before a hold and after one. This shows that the paths are combinational and that release restores them. A hold is entered with each request pin on its own. During the hold, all three live inputs are changed, and a high-impedance enable bit is raised. This tells a real capture apart from a path that still leaks the live value. A hand-off from one request pin to the other, with new live values present, shows that no recapture happens. Running the same request sequence with the feature disabled tells the enable gating apart from the hold logic, and it also shows the pass-through of the request pins to the core.

// File: rtl/pdh_pkg.sv
package pdh_pkg;
  localparam int NUM_PD = 2;

  typedef struct packed {
    logic capture;
    logic hold;
  } pdhStrobe_t;
endpackage

// File: rtl/pdh_ctrl.sv
module pdh_ctrl
  import pdh_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgPdEnable,
  input  logic [NUM_PD-1:0] pdReq,
  output pdhStrobe_t        strobe,
  output logic [NUM_PD-1:0] pdPinLogic
);
  logic reqSeen;
  logic holdQ;

  assign reqSeen = cfgPdEnable & (|pdReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdQ <= 1'b0;
    else       holdQ <= reqSeen;
  end

  // Capture only on the edge that opens a hold, never on a pin hand-off.
  assign strobe.capture = reqSeen & ~holdQ;
  assign strobe.hold    = holdQ;

  for (genvar g = 0; g < NUM_PD; g++) begin : g_pdLane
    assign pdPinLogic[g] = cfgPdEnable ? 1'b0 : pdReq[g];
  end
endmodule

// File: rtl/pdh_datapath.sv
module pdh_datapath
  import pdh_pkg::*;
#(
  parameter int NUM_IN  = 6,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  pdhStrobe_t         strobe,
  input  logic [NUM_IN-1:0]  padIn,
  output logic [NUM_IN-1:0]  coreIn,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_OUT-1:0] padOut,
  output logic [NUM_OUT-1:0] padOe
);
  logic [NUM_IN-1:0]  inHeld;
  logic [NUM_OUT-1:0] outHeld;
  logic [NUM_OUT-1:0] oeHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inHeld  <= '0;
      outHeld <= '0;
      oeHeld  <= '0;
    end else if (strobe.capture) begin
      inHeld  <= padIn;
      outHeld <= coreOut;
      oeHeld  <= coreOe;
    end
  end

  for (genvar i = 0; i < NUM_IN; i++) begin : g_inLane
    assign coreIn[i] = strobe.hold ? inHeld[i] : padIn[i];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_outLane
    assign padOut[o] = strobe.hold ? outHeld[o] : coreOut[o];
    assign padOe[o]  = strobe.hold ? oeHeld[o]  : coreOe[o];
  end
endmodule

// File: rtl/pdh_unit.sv
module pdh_unit
  import pdh_pkg::*;
#(
  parameter int NUM_IN  = 6,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgPdEnable,
  input  logic [1:0]         pdReq,
  input  logic [NUM_IN-1:0]  padIn,
  output logic [NUM_IN-1:0]  coreIn,
  output logic [1:0]         pdPinLogic,
  input  logic [NUM_OUT-1:0] coreOut,
  input  logic [NUM_OUT-1:0] coreOe,
  output logic [NUM_OUT-1:0] padOut,
  output logic [NUM_OUT-1:0] padOe,
  output logic               holdActive
);
  pdhStrobe_t strobe;

  pdh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgPdEnable(cfgPdEnable),
    .pdReq      (pdReq),
    .strobe     (strobe),
    .pdPinLogic (pdPinLogic)
  );

  pdh_datapath #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .padIn  (padIn),
    .coreIn (coreIn),
    .coreOut(coreOut),
    .coreOe (coreOe),
    .padOut (padOut),
    .padOe  (padOe)
  );

  assign holdActive = strobe.hold;
endmodule

// File: rtl/pdh_unit_chk.sv
module pdh_unit_chk #(
  parameter int NUM_IN  = 6,
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgPdEnable,
  input logic [1:0]         pdReq,
  input logic [NUM_IN-1:0]  padIn,
  input logic [NUM_IN-1:0]  coreIn,
  input logic [NUM_OUT-1:0] coreOut,
  input logic [NUM_OUT-1:0] padOut,
  input logic [NUM_OUT-1:0] coreOe,
  input logic [NUM_OUT-1:0] padOe,
  input logic               holdActive
);
  p_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgPdEnable && (|pdReq)) |=> holdActive);

  p_hold_has_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgPdEnable && (|pdReq)) |=> !holdActive);

  p_in_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && $past(holdActive)) |-> $stable(coreIn));

  p_out_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && $past(holdActive)) |-> $stable(padOut));

  p_oe_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (holdActive && $past(holdActive)) |-> $stable(padOe));

  p_disabled_no_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgPdEnable |=> !holdActive);

  p_live_r9: assert property (@(posedge clk) disable iff (!rstN)
    !holdActive |-> (coreIn == padIn && padOut == coreOut && padOe == coreOe));
endmodule

bind pdh_unit pdh_unit_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgPdEnable(cfgPdEnable),
  .pdReq      (pdReq),
  .padIn      (padIn),
  .coreIn     (coreIn),
  .coreOut    (coreOut),
  .padOut     (padOut),
  .coreOe     (coreOe),
  .padOe      (padOe),
  .holdActive (holdActive)
);

// File: tb/pdh_unit_tb.sv
module pdh_unit_tb;
  localparam int NI = 6;
  localparam int NO = 4;

  typedef struct {
    logic [NI-1:0] cin;
    logic [1:0]    pdl;
    logic [NO-1:0] pout;
    logic [NO-1:0] poe;
    logic          hold;
    string         tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgPdEnable = 1'b1;
  logic [1:0]    pdReq = 2'b00;
  logic [NI-1:0] padIn = '0;
  logic [NO-1:0] coreOut = '0;
  logic [NO-1:0] coreOe = '0;
  logic [NI-1:0] coreIn;
  logic [1:0]    pdPinLogic;
  logic [NO-1:0] padOut;
  logic [NO-1:0] padOe;
  logic          holdActive;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  expItem_t expQ[$];
  event sampleEv;

  // Reference model state
  logic          mHold = 1'b0;
  logic [NI-1:0] mIn = '0;
  logic [NO-1:0] mOut = '0;
  logic [NO-1:0] mOe = '0;

  always #2.5 clk = ~clk;

  pdh_unit #(.NUM_IN(NI), .NUM_OUT(NO)) u_dut (
    .clk(clk), .rstN(rstN), .cfgPdEnable(cfgPdEnable), .pdReq(pdReq),
    .padIn(padIn), .coreIn(coreIn), .pdPinLogic(pdPinLogic),
    .coreOut(coreOut), .coreOe(coreOe), .padOut(padOut), .padOe(padOe),
    .holdActive(holdActive)
  );

  task automatic checkOne(input string tag, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checkOne(e.tag, "holdActive", {7'b0, holdActive}, {7'b0, e.hold});
        checkOne(e.tag, "coreIn",     8'(coreIn),     8'(e.cin));
        checkOne(e.tag, "pdPinLogic", 8'(pdPinLogic), 8'(e.pdl));
        checkOne(e.tag, "padOut",     8'(padOut),     8'(e.pout));
        checkOne(e.tag, "padOe",      8'(padOe),      8'(e.poe));
      end
    end
  end

  // Driver: applies one cycle of stimulus, predicts, then advances the model.
  task automatic step(input string tag, input logic en, input logic [1:0] pd,
                      input logic [NI-1:0] pi, input logic [NO-1:0] co,
                      input logic [NO-1:0] oe);
    expItem_t e;
    logic req;
    @(negedge clk);
    cfgPdEnable = en; pdReq = pd; padIn = pi; coreOut = co; coreOe = oe;
    #1;
    e.tag  = tag;
    e.hold = mHold;
    e.cin  = mHold ? mIn  : pi;
    e.pout = mHold ? mOut : co;
    e.poe  = mHold ? mOe  : oe;
    e.pdl  = en ? 2'b00 : pd;
    expQ.push_back(e);
    ->sampleEv;
    @(posedge clk);
    req = en & (|pd);
    if (req && !mHold) begin
      mIn = pi; mOut = co; mOe = oe;
    end
    mHold = req;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state with live pass-through
    #1;
    checkOne("R1", "holdActive in reset", {7'b0, holdActive}, 8'h00);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step("R1", 1'b1, 2'b00, 6'h15, 4'hA, 4'hF);
    // R9: several live patterns
    step("R9", 1'b1, 2'b00, 6'h2A, 4'h5, 4'h3);
    step("R9", 1'b1, 2'b00, 6'h3F, 4'h0, 4'hC);
    step("R9", 1'b1, 2'b00, 6'h01, 4'h9, 4'h6);
    // R2: pin 0 alone opens a hold; entry values 0x21/0x6/0x5 (oe bit1 and bit3 hi-Z)
    step("R2", 1'b1, 2'b01, 6'h21, 4'h6, 4'h5);
    // R3 R4 R5: live changes ignored, hi-Z bits stay hi-Z
    step("R3", 1'b1, 2'b01, 6'h1E, 4'h9, 4'hF);
    step("R4", 1'b1, 2'b01, 6'h3C, 4'hF, 4'hA);
    step("R5", 1'b1, 2'b01, 6'h00, 4'h0, 4'hF);
    // R8: hand-off to pin 1 with new values, no recapture
    step("R8", 1'b1, 2'b11, 6'h33, 4'h3, 4'hF);
    step("R8", 1'b1, 2'b10, 6'h0C, 4'hC, 4'hE);
    step("R8", 1'b1, 2'b10, 6'h2D, 4'h1, 4'hF);
    // R6: release, then live again
    step("R6", 1'b1, 2'b00, 6'h12, 4'h7, 4'h9);
    step("R6", 1'b1, 2'b00, 6'h24, 4'hB, 4'h2);
    // R8: pin 1 alone opens a hold
    step("R8", 1'b1, 2'b10, 6'h0F, 4'h4, 4'h0);
    step("R5", 1'b1, 2'b10, 6'h30, 4'hB, 4'hF);
    step("R6", 1'b1, 2'b00, 6'h11, 4'h2, 4'h8);
    step("R6", 1'b1, 2'b00, 6'h22, 4'hD, 4'h7);
    // R7: feature disabled, request pins are ordinary inputs
    step("R7", 1'b0, 2'b01, 6'h05, 4'h1, 4'h1);
    step("R7", 1'b0, 2'b11, 6'h0A, 4'h2, 4'h3);
    step("R7", 1'b0, 2'b10, 6'h14, 4'h4, 4'h7);
    step("R7", 1'b0, 2'b00, 6'h28, 4'h8, 4'hF);
    // R7: enabling again masks the pins from logic and allows hold
    step("R7", 1'b1, 2'b11, 6'h3A, 4'hE, 4'hB);
    step("R7", 1'b1, 2'b11, 6'h05, 4'h1, 4'h4);
    step("R6", 1'b1, 2'b00, 6'h19, 4'h6, 4'h6);
    step("R6", 1'b1, 2'b00, 6'h26, 4'h9, 4'h9);
    @(negedge clk);
    ->sampleEv;
    #1;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule